// File: doc/BRIEF.md
# Multiplexed Queue Level Status Bus

This block reports the fill-level status of a bank of queues over two narrow buses. One bus reports almost-full conditions and runs on the write-side clock. The other reports almost-empty conditions and runs on the read-side clock. Each bus is one group of eight bits wide, so it shows eight queues at a time. With 32 queues there are four such groups, and a 2-bit group index travels beside each bus. Occupancy counts come in from the queue logic as flat vectors, one for each clock domain. Each queue has its own almost-full and almost-empty threshold, and these can be rewritten at run time through a small write port on each side.

The operating mode and the number of configured queues are captured while reset is held. In stepping mode each bus visits the four groups in turn, one group per edge of its own clock. In addressed mode each side picks its group with its own address input. The two sides remain fully independent of each other. Flag bits are active low. A bit that belongs to a queue beyond the configured count is always driven high.

Top module: `qflag_status_bus`

## Requirements
- R1: While a side's reset input is low, every rising edge of that side's clock sets its group index to 0 and its flag bus to all ones. The same edge captures `direct_mode` and `num_queues` for that side.
- R2: In stepping mode (`direct_mode` captured as 0), every rising edge out of reset moves the group index to the next value in the order 0, 1, 2, 3, 0. This order is the same whatever the configured queue count is.
- R3: In addressed mode (`direct_mode` captured as 1), every rising edge loads the group index from that side's address input. The almost-full side uses `af_quad_addr` and the almost-empty side uses `ae_quad_addr`, independently. No enable is needed.
- R4: The almost-full bus and its index change only on `wr_clk`, using `wr_occ`. The almost-empty bus and its index change only on `rd_clk`, using `rd_occ`. Each result appears one edge after its inputs are sampled.
- R5: Bit b of `af_flags_n`, shown with group index k, belongs to queue k*8+b, with bit 0 the lowest. That bit is 0 when the queue's write-side occupancy is at or above its almost-full threshold, and 1 otherwise.
- R6: Bit b of `ae_flags_n`, shown with group index k, belongs to queue k*8+b. That bit is 0 when the queue's read-side occupancy is at or below its almost-empty threshold, and 1 otherwise.
- R7: Reset sets every almost-full threshold to 200 and every almost-empty threshold to 16. A threshold write (`*_thr_we` high for one edge) is first used in a comparison on the following edge.
- R8: A bit whose queue number is at or above the captured queue count reads 1, in either mode.
- R9: A single `direct_mode` input sets the mode of both buses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock; drives the almost-full bus |
| wr_rst_n | input | 1 | Synchronous active-low reset, write side |
| rd_clk | input | 1 | Read-side clock; drives the almost-empty bus |
| rd_rst_n | input | 1 | Synchronous active-low reset, read side |
| direct_mode | input | 1 | 0 = stepping, 1 = addressed; captured during reset |
| num_queues | input | 6 | Configured queue count; captured during reset |
| wr_occ | input | 320 | Write-side occupancy, 10 bits per queue, queue 0 lowest |
| af_thr_we | input | 1 | Almost-full threshold write strobe |
| af_thr_idx | input | 5 | Queue whose almost-full threshold is written |
| af_thr_val | input | 10 | New almost-full threshold |
| af_quad_addr | input | 2 | Group address for the almost-full bus in addressed mode |
| af_flags_n | output | 8 | Almost-full flags of the shown group, active low |
| af_quad | output | 2 | Group currently shown on `af_flags_n` |
| rd_occ | input | 320 | Read-side occupancy, 10 bits per queue, queue 0 lowest |
| ae_thr_we | input | 1 | Almost-empty threshold write strobe |
| ae_thr_idx | input | 5 | Queue whose almost-empty threshold is written |
| ae_thr_val | input | 10 | New almost-empty threshold |
| ae_quad_addr | input | 2 | Group address for the almost-empty bus in addressed mode |
| ae_flags_n | output | 8 | Almost-empty flags of the shown group, active low |
| ae_quad | output | 2 | Group currently shown on `ae_flags_n` |

## Verification
Each side's index and flags are registered once. Whatever a side's inputs hold at one rising edge of its own clock (occupancy, address, thresholds) shows up on its outputs right after that edge. A threshold write is used in comparisons one edge later. The bench keeps a separate reference model for each clock domain, updated at each rising edge from the inputs present at that edge. It compares the model with the outputs at the next falling edge of the same clock, so each comparison falls exactly one register stage after its stimulus. Stimulus changes only on falling edges.

// File: rtl/qfs_pkg.sv
package qfs_pkg;

  typedef enum logic {
    QFS_POLLED = 1'b0,
    QFS_DIRECT = 1'b1
  } qfs_mode_e;

  // Level test: full sense trips at or above, empty sense at or below.
  function automatic bit qfs_level_hit(input bit sense_full,
                                       input int unsigned occ,
                                       input int unsigned thr);
    return sense_full ? (occ >= thr) : (occ <= thr);
  endfunction

  // A queue number is live when it lies below the configured count.
  function automatic bit qfs_q_used(input int unsigned qidx,
                                    input int unsigned ncfg);
    return qidx < ncfg;
  endfunction

endpackage

// File: rtl/qfs_thr_bank.sv
module qfs_thr_bank #(
  parameter int NUM_Q   = 32,
  parameter int OCC_W   = 10,
  parameter int THR_DEF = 200,
  localparam int QIDX_W = $clog2(NUM_Q)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              thr_we,
  input  logic [QIDX_W-1:0] thr_idx,
  input  logic [OCC_W-1:0]  thr_val,
  output logic [OCC_W-1:0]  thr_a [NUM_Q]
);

  for (genvar q = 0; q < NUM_Q; q++) begin : g_thr
    always_ff @(posedge clk) begin
      if (!rst_n)
        thr_a[q] <= OCC_W'(THR_DEF);
      else if (thr_we && (thr_idx == QIDX_W'(q)))
        thr_a[q] <= thr_val;
    end
  end

  // R7
  thr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_we |=> thr_a[$past(thr_idx)] == $past(thr_val));

endmodule

// File: rtl/qfs_quad_seq.sv
module qfs_quad_seq
  import qfs_pkg::*;
#(
  parameter int NUM_GRP = 4,
  localparam int GSEL_W = $clog2(NUM_GRP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_in,
  input  logic [GSEL_W-1:0] addr_i,
  output logic [GSEL_W-1:0] quad_o,
  output logic [GSEL_W-1:0] quad_nxt_o
);

  qfs_mode_e mode_q;
  logic [GSEL_W-1:0] quad_q;
  logic [GSEL_W-1:0] step_val;

  assign step_val = (quad_q == GSEL_W'(NUM_GRP - 1)) ? '0 : quad_q + 1'b1;

  always_comb begin
    if (mode_q == QFS_DIRECT) quad_nxt_o = addr_i;
    else                      quad_nxt_o = step_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= qfs_mode_e'(mode_in);
      quad_q <= '0;
    end else begin
      quad_q <= quad_nxt_o;
    end
  end

  assign quad_o = quad_q;

  // R2
  polled_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == QFS_POLLED) |=>
      quad_o == (($past(quad_o) == GSEL_W'(NUM_GRP - 1)) ? '0 : $past(quad_o) + 1'b1));

  // R3
  direct_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == QFS_DIRECT) |=> quad_o == $past(addr_i));

endmodule

// File: rtl/qfs_side.sv
module qfs_side
  import qfs_pkg::*;
#(
  parameter bit SENSE_FULL = 1'b1,
  parameter int NUM_Q      = 32,
  parameter int GRP_W      = 8,
  parameter int OCC_W      = 10,
  parameter int THR_DEF    = 200,
  localparam int NUM_GRP   = NUM_Q / GRP_W,
  localparam int GSEL_W    = $clog2(NUM_GRP),
  localparam int QIDX_W    = $clog2(NUM_Q),
  localparam int QCNT_W    = $clog2(NUM_Q + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mode_in,
  input  logic [QCNT_W-1:0]      ncfg_in,
  input  logic [NUM_Q*OCC_W-1:0] occ_flat,
  input  logic                   thr_we,
  input  logic [QIDX_W-1:0]      thr_idx,
  input  logic [OCC_W-1:0]       thr_val,
  input  logic [GSEL_W-1:0]      quad_addr,
  output logic [GRP_W-1:0]       bus_n,
  output logic [GSEL_W-1:0]      quad
);

  logic [OCC_W-1:0]  occ_a [NUM_Q];
  logic [OCC_W-1:0]  thr_a [NUM_Q];
  logic [GSEL_W-1:0] quad_nxt;
  logic [QCNT_W-1:0] ncfg_q;
  logic [GRP_W-1:0]  flag_nxt;
  logic [GRP_W-1:0]  bus_q;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_occ
    assign occ_a[q] = occ_flat[q*OCC_W +: OCC_W];
  end

  qfs_thr_bank #(
    .NUM_Q   (NUM_Q),
    .OCC_W   (OCC_W),
    .THR_DEF (THR_DEF)
  ) u_thr (
    .clk     (clk),
    .rst_n   (rst_n),
    .thr_we  (thr_we),
    .thr_idx (thr_idx),
    .thr_val (thr_val),
    .thr_a   (thr_a)
  );

  qfs_quad_seq #(
    .NUM_GRP (NUM_GRP)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_in    (mode_in),
    .addr_i     (quad_addr),
    .quad_o     (quad),
    .quad_nxt_o (quad_nxt)
  );

  // Flags of the group about to be shown, active low, unused forced high.
  always_comb begin
    for (int b = 0; b < GRP_W; b++) begin
      logic [QIDX_W-1:0] qi;
      qi = QIDX_W'(32'(quad_nxt) * GRP_W + b);
      flag_nxt[b] = ~(qfs_q_used(32'(qi), 32'(ncfg_q)) &&
                      qfs_level_hit(SENSE_FULL, 32'(occ_a[qi]), 32'(thr_a[qi])));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ncfg_q <= ncfg_in;
      bus_q  <= '1;
    end else begin
      bus_q  <= flag_nxt;
    end
  end

  assign bus_n = bus_q;

  // R8
  unused_quad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(ncfg_q) <= 32'(quad_nxt) * GRP_W) |=> (bus_n == '1));

endmodule

// File: rtl/qflag_status_bus.sv
module qflag_status_bus #(
  parameter int NUM_Q      = 32,
  parameter int GRP_W      = 8,
  parameter int OCC_W      = 10,
  parameter int AF_THR_DEF = 200,
  parameter int AE_THR_DEF = 16,
  localparam int NUM_GRP   = NUM_Q / GRP_W,
  localparam int GSEL_W    = $clog2(NUM_GRP),
  localparam int QIDX_W    = $clog2(NUM_Q),
  localparam int QCNT_W    = $clog2(NUM_Q + 1)
) (
  input  logic                   wr_clk,
  input  logic                   wr_rst_n,
  input  logic                   rd_clk,
  input  logic                   rd_rst_n,
  input  logic                   direct_mode,
  input  logic [QCNT_W-1:0]      num_queues,
  input  logic [NUM_Q*OCC_W-1:0] wr_occ,
  input  logic                   af_thr_we,
  input  logic [QIDX_W-1:0]      af_thr_idx,
  input  logic [OCC_W-1:0]       af_thr_val,
  input  logic [GSEL_W-1:0]      af_quad_addr,
  output logic [GRP_W-1:0]       af_flags_n,
  output logic [GSEL_W-1:0]      af_quad,
  input  logic [NUM_Q*OCC_W-1:0] rd_occ,
  input  logic                   ae_thr_we,
  input  logic [QIDX_W-1:0]      ae_thr_idx,
  input  logic [OCC_W-1:0]       ae_thr_val,
  input  logic [GSEL_W-1:0]      ae_quad_addr,
  output logic [GRP_W-1:0]       ae_flags_n,
  output logic [GSEL_W-1:0]      ae_quad
);

  // R9: one mode input feeds both sides; each captures it in its own reset.
  qfs_side #(
    .SENSE_FULL (1'b1),
    .NUM_Q      (NUM_Q),
    .GRP_W      (GRP_W),
    .OCC_W      (OCC_W),
    .THR_DEF    (AF_THR_DEF)
  ) u_af_side (
    .clk       (wr_clk),
    .rst_n     (wr_rst_n),
    .mode_in   (direct_mode),
    .ncfg_in   (num_queues),
    .occ_flat  (wr_occ),
    .thr_we    (af_thr_we),
    .thr_idx   (af_thr_idx),
    .thr_val   (af_thr_val),
    .quad_addr (af_quad_addr),
    .bus_n     (af_flags_n),
    .quad      (af_quad)
  );

  qfs_side #(
    .SENSE_FULL (1'b0),
    .NUM_Q      (NUM_Q),
    .GRP_W      (GRP_W),
    .OCC_W      (OCC_W),
    .THR_DEF    (AE_THR_DEF)
  ) u_ae_side (
    .clk       (rd_clk),
    .rst_n     (rd_rst_n),
    .mode_in   (direct_mode),
    .ncfg_in   (num_queues),
    .occ_flat  (rd_occ),
    .thr_we    (ae_thr_we),
    .thr_idx   (ae_thr_idx),
    .thr_val   (ae_thr_val),
    .quad_addr (ae_quad_addr),
    .bus_n     (ae_flags_n),
    .quad      (ae_quad)
  );

endmodule

// File: tb/test_qflag_status_bus.sv
module test_qflag_status_bus;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = 14;
  localparam int NQ = 32;
  localparam int GW = 8;
  localparam int OW = 10;
  localparam int NG = 4;
  localparam int AF_DEF = 200;
  localparam int AE_DEF = 16;

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

  logic wr_rst_n = 1'b0, rd_rst_n = 1'b0, direct_mode = 1'b0;
  logic [5:0] num_queues = 6'd32;
  logic [NQ*OW-1:0] wr_occ, rd_occ;
  logic af_thr_we = 1'b0, ae_thr_we = 1'b0;
  logic [4:0] af_thr_idx = '0, ae_thr_idx = '0;
  logic [OW-1:0] af_thr_val = '0, ae_thr_val = '0;
  logic [1:0] af_quad_addr = '0, ae_quad_addr = '0;
  logic [7:0] af_flags_n, ae_flags_n;
  logic [1:0] af_quad, ae_quad;

  int occ_w[NQ], occ_r[NQ];
  bit rnd_occ = 1'b0, rnd_addr = 1'b0;
  int checks = 0, failures = 0;
  string phase = "R1";

  always_comb
    for (int q = 0; q < NQ; q++) begin
      wr_occ[q*OW +: OW] = OW'(occ_w[q]);
      rd_occ[q*OW +: OW] = OW'(occ_r[q]);
    end

  qflag_status_bus i_qflag_status_bus (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
    .direct_mode(direct_mode), .num_queues(num_queues),
    .wr_occ(wr_occ), .af_thr_we(af_thr_we), .af_thr_idx(af_thr_idx),
    .af_thr_val(af_thr_val), .af_quad_addr(af_quad_addr),
    .af_flags_n(af_flags_n), .af_quad(af_quad),
    .rd_occ(rd_occ), .ae_thr_we(ae_thr_we), .ae_thr_idx(ae_thr_idx),
    .ae_thr_val(ae_thr_val), .ae_quad_addr(ae_quad_addr),
    .ae_flags_n(ae_flags_n), .ae_quad(ae_quad)
  );

  task automatic check(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s [phase %s] %s got %0h exp %0h", tag, phase, what, got, exp);
    end
  endtask

  // Reference model, write side (almost full)
  int m_w_dir, m_w_n, m_w_quad;
  logic [7:0] m_w_bus;
  int m_af_thr[NQ];
  bit w_live = 1'b0;
  always @(posedge wr_clk) begin
    if (!wr_rst_n) begin
      m_w_dir = int'(direct_mode); m_w_n = int'(num_queues);
      m_w_quad = 0; m_w_bus = 8'hFF; w_live = 1'b1;
      foreach (m_af_thr[i]) m_af_thr[i] = AF_DEF;
    end else begin
      int nq;
      nq = (m_w_dir != 0) ? int'(af_quad_addr) : (m_w_quad + 1) % NG;
      for (int b = 0; b < GW; b++) begin
        int q;
        q = nq * GW + b;
        m_w_bus[b] = (q < m_w_n && occ_w[q] >= m_af_thr[q]) ? 1'b0 : 1'b1;
      end
      m_w_quad = nq;
      if (af_thr_we) m_af_thr[af_thr_idx] = int'(af_thr_val);
    end
  end

  // Reference model, read side (almost empty)
  int m_r_dir, m_r_n, m_r_quad;
  logic [7:0] m_r_bus;
  int m_ae_thr[NQ];
  bit r_live = 1'b0;
  always @(posedge rd_clk) begin
    if (!rd_rst_n) begin
      m_r_dir = int'(direct_mode); m_r_n = int'(num_queues);
      m_r_quad = 0; m_r_bus = 8'hFF; r_live = 1'b1;
      foreach (m_ae_thr[i]) m_ae_thr[i] = AE_DEF;
    end else begin
      int nq;
      nq = (m_r_dir != 0) ? int'(ae_quad_addr) : (m_r_quad + 1) % NG;
      for (int b = 0; b < GW; b++) begin
        int q;
        q = nq * GW + b;
        m_r_bus[b] = (q < m_r_n && occ_r[q] <= m_ae_thr[q]) ? 1'b0 : 1'b1;
      end
      m_r_quad = nq;
      if (ae_thr_we) m_ae_thr[ae_thr_idx] = int'(ae_thr_val);
    end
  end

  // Compare one register stage after each edge (R4: per-domain timing)
  always @(negedge wr_clk)
    if (w_live) begin
      check((m_w_dir != 0) ? "R3" : "R2", "af_quad", int'(af_quad), m_w_quad);
      check("R5", "af_flags_n", int'(af_flags_n), int'(m_w_bus));
    end
  always @(negedge rd_clk)
    if (r_live) begin
      check((m_r_dir != 0) ? "R3" : "R2", "ae_quad", int'(ae_quad), m_r_quad);
      check("R6", "ae_flags_n", int'(ae_flags_n), int'(m_r_bus));
    end

  // Stimulus drivers
  always @(negedge wr_clk) begin
    if (rnd_occ) foreach (occ_w[i]) occ_w[i] = $urandom_range(0, 255);
    if (rnd_addr) af_quad_addr = 2'($urandom_range(0, 3));
  end
  always @(negedge rd_clk) begin
    if (rnd_occ) foreach (occ_r[i]) occ_r[i] = $urandom_range(0, 255);
    if (rnd_addr) ae_quad_addr = 2'($urandom_range(0, 3));
  end

  task automatic do_reset(bit dir, int n);
    wr_rst_n = 1'b0; rd_rst_n = 1'b0;
    direct_mode = dir; num_queues = 6'(n);
    repeat (4) @(negedge rd_clk);
    @(negedge wr_clk) wr_rst_n = 1'b1;
    @(negedge rd_clk) rd_rst_n = 1'b1;
  endtask

  task automatic wr_af_thr(int q, int v);
    @(negedge wr_clk);
    af_thr_we = 1'b1; af_thr_idx = 5'(q); af_thr_val = OW'(v);
    @(negedge wr_clk) af_thr_we = 1'b0;
  endtask

  task automatic wr_ae_thr(int q, int v);
    @(negedge rd_clk);
    ae_thr_we = 1'b1; ae_thr_idx = 5'(q); ae_thr_val = OW'(v);
    @(negedge rd_clk) ae_thr_we = 1'b0;
  endtask

  initial begin
    foreach (occ_w[i]) begin occ_w[i] = 0; occ_r[i] = 0; end
    // R1: reset state, then stepping through groups (R2) with random levels
    phase = "R1";
    do_reset(1'b0, 32);
    phase = "R2"; rnd_occ = 1'b1;
    repeat (30) @(negedge wr_clk);
    // R7: run-time threshold writes
    phase = "R7";
    wr_af_thr(5, 40); wr_af_thr(9, 0);
    wr_ae_thr(12, 300); wr_ae_thr(30, 0);
    repeat (20) @(negedge wr_clk);
    // R5 / R6 boundaries: occupancy equal to and one past threshold
    phase = "R5_R6_edge"; rnd_occ = 1'b0;
    foreach (occ_w[i]) begin occ_w[i] = i * 7; occ_r[i] = i * 3; end
    wr_af_thr(3, 21); wr_af_thr(4, 29);
    wr_ae_thr(10, 30); wr_ae_thr(11, 32);
    repeat (12) @(negedge rd_clk);
    // R8: 22 configured queues, stepping still covers four groups
    phase = "R8"; rnd_occ = 1'b1;
    do_reset(1'b0, 22);
    repeat (30) @(negedge wr_clk);
    // R3 / R4: addressed mode, sides addressed independently
    phase = "R3"; rnd_addr = 1'b1;
    do_reset(1'b1, 32);
    repeat (40) @(negedge wr_clk);
    // R9: shared mode input, addressed with masking
    phase = "R9";
    do_reset(1'b1, 13);
    repeat (30) @(negedge rd_clk);
    rnd_addr = 1'b0; rnd_occ = 1'b0;
    repeat (3) @(negedge rd_clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge wr_clk);
    failures++;
    $display("FAIL watchdog [phase %s] got timeout exp completion", phase);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule